// File: doc/BRIEF.md
# Integer Add Unit with Condition Codes

This block is the integer add stage of a shader-style ALU. It takes two operands, optionally negates either one (two's complement) before the sum, and optionally shifts the first operand left for a shift-and-add form. In extended (multi-word) mode it also adds the carry bit held in its own condition-code register, so that a wide sum can be built from a chain of word-sized adds.

When the set-condition-code control is high on an accepted operation, the unit rewrites its four flags: carry, overflow, zero and sign. The carry is not taken from the adder's carry chain. It is rebuilt by comparing the sum with the effective first operand. When the stored carry was added in, the rule also treats equality as a carry. The result, the flags and a valid strobe are all registered together, one cycle after the inputs are accepted.

Top module: `iadd_cc_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `res_o` is 0, `cc_o` is 0 and `out_vld_o` is 0.
- R2: `out_vld_o` equals the `in_vld_i` value of the previous cycle.
- R3: For an accepted operation, `res_o` (one cycle later) is Aeff + Beff modulo 2^W. Aeff is `a_i` (shifted left by `shamt_i` when `shadd_i` is high), negated when `neg_a_i` is high. Beff is `b_i`, negated when `neg_b_i` is high.
- R4: With `ext_i` high and `shadd_i` low, the stored carry (`cc_o[2]`) is added once more to the sum. It is added as-is, never inverted, even when an operand is negated.
- R5: `cc_o` changes only on a cycle where `in_vld_i` and `setcc_i` are both high. Otherwise every flag keeps its value.
- R6: Without extended mode, the new carry `cc_o[2]` is 1 exactly when the result is unsigned-less-than Aeff.
- R7: In extended mode, the new carry is 1 when the result is unsigned-less-than Aeff, or when the result equals Aeff and the stored carry was 1.
- R8: The new overflow `cc_o[3]` is the top bit of (result XOR Aeff) AND NOT (Aeff XOR Beff).
- R9: The new zero flag `cc_o[0]` is 1 when the result is all zeros. The new sign flag `cc_o[1]` equals the result's top bit.
- R10: With `shadd_i` high, `ext_i` has no effect: no carry is added, and the carry follows the R6 rule.
- R11: `res_o` holds its value on cycles that follow an idle input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Operation accepted this cycle |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| neg_a_i | input | 1 | Negate the (shifted) first operand |
| neg_b_i | input | 1 | Negate the second operand |
| ext_i | input | 1 | Extended mode: add stored carry |
| setcc_i | input | 1 | Update the condition codes |
| shadd_i | input | 1 | Shift-and-add form |
| shamt_i | input | $clog2(W) | Left shift amount of the first operand |
| out_vld_o | output | 1 | Result valid |
| res_o | output | W | Registered result |
| cc_o | output | 4 | Flags: [0] zero, [1] sign, [2] carry, [3] overflow |

## Verification
The bench builds the unit with W = 32. At that width the all-ones and sign-boundary operands are easy to reach, as are carry chains across two words and shift amounts up to 31. Directed steps drive the result into equality with the first operand while the stored carry is set, which is the only case where the two carry rules differ. A long pseudo-random run then mixes negation, extended mode, shift-and-add and flag-update enables, so that carries from earlier operations feed later extended sums.

// File: rtl/iadd_pkg.sv
package iadd_pkg;

    typedef struct packed {
        logic ovf;
        logic carry;
        logic sign;
        logic zero;
    } cc_t;

    localparam cc_t CC_CLEAR = '{ovf: 1'b0, carry: 1'b0, sign: 1'b0, zero: 1'b0};

    function automatic logic signed_ovf_bit(input logic res_msb, input logic a_msb,
                                            input logic b_msb);
        return (res_msb ^ a_msb) & ~(a_msb ^ b_msb);
    endfunction

endpackage

// File: rtl/iadd_operand_prep.sv
module iadd_operand_prep #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          neg_a_i,
    input  logic          neg_b_i,
    input  logic          shadd_i,
    input  logic [SW-1:0] shamt_i,
    output logic [W-1:0]  a_eff_o,
    output logic [W-1:0]  b_eff_o
);
    logic [W-1:0] a_shifted;

    always_comb begin
        a_shifted = shadd_i ? (a_i << shamt_i) : a_i;
        a_eff_o   = neg_a_i ? (~a_shifted + 1'b1) : a_shifted;
        b_eff_o   = neg_b_i ? (~b_i + 1'b1) : b_i;
    end
endmodule

// File: rtl/iadd_sum.sv
module iadd_sum #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);
    always_comb begin
        sum_o = a_i + b_i + {{(W-1){1'b0}}, cin_i};
    end
endmodule

// File: rtl/iadd_flag_gen.sv
module iadd_flag_gen
    import iadd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ext_i,
    input  logic         cin_i,
    output cc_t          cc_o
);
    logic below_a;
    logic equal_a;

    always_comb begin
        below_a    = sum_i < a_i;
        equal_a    = sum_i == a_i;
        cc_o.carry = ext_i ? (below_a | (equal_a & cin_i)) : below_a;
        cc_o.ovf   = signed_ovf_bit(sum_i[W-1], a_i[W-1], b_i[W-1]);
        cc_o.zero  = ~|sum_i;
        cc_o.sign  = sum_i[W-1];
    end
endmodule

// File: rtl/iadd_cc_unit.sv
module iadd_cc_unit
    import iadd_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          neg_a_i,
    input  logic          neg_b_i,
    input  logic          ext_i,
    input  logic          setcc_i,
    input  logic          shadd_i,
    input  logic [SW-1:0] shamt_i,
    output logic          out_vld_o,
    output logic [W-1:0]  res_o,
    output logic [3:0]    cc_o
);
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         ext_eff;
    logic         cin_add;
    cc_t          cc_q;
    cc_t          cc_next;

    assign ext_eff = ext_i & ~shadd_i;
    assign cin_add = ext_eff & cc_q.carry;

    iadd_operand_prep #(.W(W), .SW(SW)) u_prep (
        .a_i     (a_i),
        .b_i     (b_i),
        .neg_a_i (neg_a_i),
        .neg_b_i (neg_b_i),
        .shadd_i (shadd_i),
        .shamt_i (shamt_i),
        .a_eff_o (a_eff),
        .b_eff_o (b_eff)
    );

    iadd_sum #(.W(W)) u_sum (
        .a_i   (a_eff),
        .b_i   (b_eff),
        .cin_i (cin_add),
        .sum_o (sum)
    );

    iadd_flag_gen #(.W(W)) u_flags (
        .sum_i (sum),
        .a_i   (a_eff),
        .b_i   (b_eff),
        .ext_i (ext_eff),
        .cin_i (cc_q.carry),
        .cc_o  (cc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_o <= 1'b0;
            res_o     <= '0;
            cc_q      <= CC_CLEAR;
        end else begin
            out_vld_o <= in_vld_i;
            if (in_vld_i) begin
                res_o <= sum;
                if (setcc_i) begin
                    cc_q <= cc_next;
                end
            end
        end
    end

    assign cc_o = cc_q;
endmodule

// File: rtl/iadd_cc_checker.sv
module iadd_cc_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_vld_i,
    input logic         setcc_i,
    input logic         out_vld_o,
    input logic [W-1:0] res_o,
    input logic [3:0]   cc_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_vld_o && res_o == '0 && cc_o == 4'd0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_vld_i |=> out_vld_o);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> !out_vld_o);

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_vld_i && setcc_i) |=> $stable(cc_o));

    a_r9_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && setcc_i) |=> (cc_o[0] == (res_o == '0)));

    a_r9_sign_tracks: assert property (@(posedge clk) disable iff (rst)
        (in_vld_i && setcc_i) |=> (cc_o[1] == res_o[W-1]));

    a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld_i |=> $stable(res_o));
endmodule

bind iadd_cc_unit iadd_cc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld_i  (in_vld_i),
    .setcc_i   (setcc_i),
    .out_vld_o (out_vld_o),
    .res_o     (res_o),
    .cc_o      (cc_o)
);

// File: tb/iadd_cc_unit_tb.sv
module iadd_cc_unit_tb;
    localparam int W = 32;
    localparam int SW = $clog2(W);
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_vld_i, neg_a_i, neg_b_i, ext_i, setcc_i, shadd_i;
    logic [W-1:0]  a_i, b_i;
    logic [SW-1:0] shamt_i;
    logic          out_vld_o;
    logic [W-1:0]  res_o;
    logic [3:0]    cc_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [W-1:0] m_res;
    logic [3:0]   m_cc;
    logic         m_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    iadd_cc_unit #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .in_vld_i(in_vld_i), .a_i(a_i), .b_i(b_i),
        .neg_a_i(neg_a_i), .neg_b_i(neg_b_i), .ext_i(ext_i), .setcc_i(setcc_i),
        .shadd_i(shadd_i), .shamt_i(shamt_i), .out_vld_o(out_vld_o),
        .res_o(res_o), .cc_o(cc_o)
    );

    task automatic check(input string tag);
        checks++;
        if (out_vld_o !== m_vld || res_o !== m_res || cc_o !== m_cc) begin
            failures++;
            $display("FAIL %s: vld=%0b res=%h cc=%b expected vld=%0b res=%h cc=%b",
                     tag, out_vld_o, res_o, cc_o, m_vld, m_res, m_cc);
        end
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic na, input logic nb, input logic ex, input logic cc,
                        input logic sh, input int s, input string tag);
        logic [W-1:0] ae, be, r;
        logic         ext_on, c_in;
        in_vld_i = v; a_i = a; b_i = b; neg_a_i = na; neg_b_i = nb;
        ext_i = ex; setcc_i = cc; shadd_i = sh; shamt_i = SW'(s);
        ae = sh ? (a << s) : a;
        if (na) ae = -ae;
        be = nb ? -b : b;
        ext_on = ex && !sh;
        c_in = ext_on ? m_cc[2] : 1'b0;
        r = ae + be + W'(c_in);
        m_vld = v;
        if (v) begin
            if (cc) begin
                m_cc[2] = (r < ae) || (ext_on && r == ae && m_cc[2]);
                m_cc[3] = (r[W-1] != ae[W-1]) && (ae[W-1] == be[W-1]);
                m_cc[0] = (r == 0);
                m_cc[1] = r[W-1];
            end
            m_res = r;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_vld_i = 0; a_i = 0; b_i = 0; neg_a_i = 0; neg_b_i = 0;
        ext_i = 0; setcc_i = 0; shadd_i = 0; shamt_i = 0;
        m_res = 0; m_cc = 0; m_vld = 0;
        repeat (3) @(negedge clk);
        check("R1 during reset");
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 after reset");
        step(1, 5, 7, 0, 0, 0, 1, 0, 0, "R3 plain sum");
        step(1, 32'hFFFF_FFFF, 1, 0, 0, 0, 1, 0, 0, "R6 R9 wrap carry zero");
        step(1, 0, 0, 0, 0, 1, 1, 0, 0, "R4 ext adds carry");
        step(1, 32'hFFFF_FFFF, 1, 0, 0, 0, 1, 0, 0, "R6 set carry again");
        step(1, 5, 32'hFFFF_FFFF, 0, 0, 1, 1, 0, 0, "R7 equal with carry in");
        step(1, 3, 10, 1, 0, 0, 1, 0, 0, "R3 R6 negate A");
        step(1, 20, 6, 0, 1, 1, 1, 0, 0, "R4 negate B carry not inverted");
        step(1, 32'h7FFF_FFFF, 1, 0, 0, 0, 1, 0, 0, "R8 R9 signed overflow");
        step(1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 1, 0, 0, "R8 negative overflow");
        step(1, 9, 9, 0, 0, 0, 0, 0, 0, "R5 no setcc flags hold");
        step(0, 1, 1, 0, 0, 0, 1, 0, 0, "R2 R11 idle holds");
        step(1, 32'hFFFF_FFFF, 1, 0, 0, 0, 1, 0, 0, "R6 carry before shadd");
        step(1, 3, 1, 0, 0, 1, 1, 1, 4, "R10 shadd ignores ext");
        step(1, 1, 0, 1, 0, 0, 1, 1, 31, "R10 shadd negate shifted");
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if ((i % 7) == 0) rb = ~ra;
            step(($urandom() % 5) != 0, ra, rb, $urandom() % 2, $urandom() % 2,
                 $urandom() % 2, ($urandom() % 4) != 0, ($urandom() % 4) == 0,
                 $urandom() % W, "R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule